// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a small synchronous SRAM with burst support and a pipelined read path. Each word is made of byte lanes. A lane carries eight data bits and one parity bit. The default build has four lanes, so a word is 36 bits wide. With `LANES = 2` the word is 18 bits wide. Lane `i` occupies bits `[9*i+8 : 9*i]`, and bit `9*i+8` is that lane's parity bit.

Every synchronous input is captured on the rising clock edge. A burst begins when one of two address strobes loads a new address. The CPU-side strobe always starts a read. The controller-side strobe starts a read or a write, depending on the write controls. After the load, each cycle with the advance input high moves to the next beat. The beat position is formed from the two low address bits, in linear or interleaved order. A static mode input picks the order, and that input is used unregistered. Writes merge only the enabled lanes into the stored word. An all-lane write input overrides the per-lane enables. Read data passes through the array register and then an output register. The output-enable input gates the result without a clock.

Top module: `burst_sram`

## Requirements
- R1: A read whose load or advance is presented in the cycle before rising edge k drives its word on `dq_o` from just after edge k+2 until edge k+3. A four-beat read burst therefore follows a 3-1-1-1 pattern.
- R2: Each cycle that has `adv_i` high, no strobe, and a selected device performs one access at the next beat position. Back-to-back advances give one word per clock.
- R3: With `ilv_i = 0` the beat address keeps the loaded upper bits. Its low two bits are (start + beat) mod 4, with beat = 0, 1, 2, 3.
- R4: With `ilv_i = 1` the low two bits are start XOR beat. `ilv_i` is not registered.
- R5: `strb_cpu_i` loads the address and performs a read. In that cycle the write inputs are ignored. It takes priority when `strb_ctl_i` is also high.
- R6: `strb_ctl_i` (without `strb_cpu_i`) loads the address. It performs a write when the effective lane mask is nonzero and a read otherwise. Advance beats follow the same rule.
- R7: When `all_we_i = 0`, lane i is written only if `lane_we_en_i = 1` and `lane_we_i[i] = 1`. The other lanes, including their parity bits, keep their stored value. A zero mask makes the access a read.
- R8: `all_we_i = 1` writes all lanes, whatever `lane_we_en_i` and `lane_we_i` hold.
- R9: A load with `ce_i = 0` deselects the device. From then on there are no writes, no read data, and advances have no effect, until a load with `ce_i = 1`.
- R10: `dq_o` is all Z whenever `oe_i = 0`, combinationally. It is also all Z in output cycles that carry no read word.
- R11: A cycle with no strobe and `adv_i = 0` makes no access and holds the burst position. A later advance continues from that position.
- R12: A synchronous active-high `rst` deselects the device and empties the read pipeline, so `dq_o` is Z after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address, captured on a strobe |
| wdata_i | input | 9*LANES | Write word, lane i at bits [9i+8:9i] |
| ce_i | input | 1 | Chip enable, sampled on a strobe |
| strb_cpu_i | input | 1 | CPU-side address strobe (read-only load) |
| strb_ctl_i | input | 1 | Controller-side address strobe |
| adv_i | input | 1 | Burst advance |
| lane_we_i | input | LANES | Per-lane write enables |
| lane_we_en_i | input | 1 | Master enable for the lane enables |
| all_we_i | input | 1 | All-lane write override |
| ilv_i | input | 1 | Burst order: 0 linear, 1 interleaved (unregistered) |
| oe_i | input | 1 | Output enable, unregistered |
| dq_o | output | 9*LANES | Read data, Z when not driven |

## Verification
The assertions assume that `ilv_i` stays stable for the whole of any burst. A change could land between the capture edge and the cycle that decodes the beat address. The assertions also assume that reads target only words that were written earlier, because the array has no reset value. The stimulus fills every address it later reads before reading it. It changes the burst order only across several idle cycles. It drives all inputs at the falling edge, so the unregistered mode and output-enable inputs are settled before any decode that uses them.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANE_BITS  = 9;
  localparam int BEAT_BITS  = 2;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  function automatic logic [BEAT_BITS-1:0] beat_low(
    input logic [BEAT_BITS-1:0] start,
    input logic [BEAT_BITS-1:0] beat,
    input logic                 interleave
  );
    return interleave ? (start ^ beat) : BEAT_BITS'(start + beat);
  endfunction
endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              ld_sel,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              adv,
  input  logic              ilv,
  output logic              acc_valid,
  output logic [ADDR_W-1:0] acc_addr
);
  logic [ADDR_W-1:0]    base_q, base_n;
  logic [BEAT_BITS-1:0] beat_q, beat_n;
  logic                 sel_q, sel_n;
  logic                 step;

  always_comb begin
    step   = !load && adv && sel_q;
    base_n = load ? ld_addr : base_q;
    sel_n  = load ? ld_sel : sel_q;
    if (load)      beat_n = '0;
    else if (step) beat_n = BEAT_BITS'(beat_q + 1'b1);
    else           beat_n = beat_q;
    acc_valid = load ? ld_sel : step;
    acc_addr  = {base_n[ADDR_W-1:BEAT_BITS],
                 beat_low(base_n[BEAT_BITS-1:0], beat_n, ilv)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
      sel_q  <= 1'b0;
    end else begin
      base_q <= base_n;
      beat_q <= beat_n;
      sel_q  <= sel_n;
    end
  end

  // R3: a load restarts the beat count
  a_r3_load_restarts: assert property (@(posedge clk) disable iff (rst)
    load |=> (beat_q == '0));

  // R2: each advance step moves the beat by exactly one, wrapping at four
  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    step |=> (BEAT_BITS'(beat_q - $past(beat_q)) == BEAT_BITS'(1)));

  // R11: with no load and no advance the burst position is held
  a_r11_suspend_holds: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> ($stable(beat_q) && $stable(base_q)));

  // R9: a deselecting load yields no access and no later advance steps
  a_r9_deselect_blocks: assert property (@(posedge clk) disable iff (rst)
    (load && !ld_sel) |=> !sel_q);
endmodule

// File: rtl/sram_lane.sv
module sram_lane #(
  parameter int ADDR_W = 8,
  parameter int WIDTH  = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wd,
  output logic [WIDTH-1:0]  rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) rd_q <= mem[addr];
  end

  assign rd = rd_q;

  // R5/R6: one lane port never reads and writes in the same cycle
  always_comb begin
    a_r6_lane_exclusive: assert (!(we && re));
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import sram_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [LANES*LANE_BITS-1:0] wdata_i,
  input  logic                       ce_i,
  input  logic                       strb_cpu_i,
  input  logic                       strb_ctl_i,
  input  logic                       adv_i,
  input  logic [LANES-1:0]           lane_we_i,
  input  logic                       lane_we_en_i,
  input  logic                       all_we_i,
  input  logic                       ilv_i,
  input  logic                       oe_i,
  output logic [LANES*LANE_BITS-1:0] dq_o
);
  localparam int DW = LANES * LANE_BITS;

  // input capture registers
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     wd_q;
  logic              ce_q, cpu_q, ctl_q, adv_q, en_q, all_q;
  logic [LANES-1:0]  lwe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      wd_q   <= '0;
      ce_q   <= 1'b0;
      cpu_q  <= 1'b0;
      ctl_q  <= 1'b0;
      adv_q  <= 1'b0;
      en_q   <= 1'b0;
      all_q  <= 1'b0;
      lwe_q  <= '0;
    end else begin
      addr_q <= addr_i;
      wd_q   <= wdata_i;
      ce_q   <= ce_i;
      cpu_q  <= strb_cpu_i;
      ctl_q  <= strb_ctl_i;
      adv_q  <= adv_i;
      en_q   <= lane_we_en_i;
      all_q  <= all_we_i;
      lwe_q  <= lane_we_i;
    end
  end

  // decode
  logic              load, acc_valid;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  mask, lane_we;
  acc_kind_e         kind;

  assign load = cpu_q | ctl_q;

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .ld_sel    (ce_q),
    .ld_addr   (addr_q),
    .adv       (adv_q),
    .ilv       (ilv_i),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr)
  );

  always_comb begin
    if (all_q)     mask = '1;
    else if (en_q) mask = lwe_q;
    else           mask = '0;
    if (!acc_valid)             kind = ACC_NONE;
    else if (!cpu_q && |mask)   kind = ACC_WRITE;
    else                        kind = ACC_READ;
    lane_we = (kind == ACC_WRITE) ? mask : '0;
  end

  // lane arrays
  logic [DW-1:0] rd_word;
  logic          is_rd;
  assign is_rd = (kind == ACC_READ);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_lane #(.ADDR_W(ADDR_W), .WIDTH(LANE_BITS)) u_lane (
      .clk  (clk),
      .we   (lane_we[g]),
      .re   (is_rd),
      .addr (acc_addr),
      .wd   (wd_q[g*LANE_BITS +: LANE_BITS]),
      .rd   (rd_word[g*LANE_BITS +: LANE_BITS])
    );
  end

  // read pipeline
  logic          rd_v1, out_v;
  logic [DW-1:0] out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v1 <= 1'b0;
      out_v <= 1'b0;
      out_q <= '0;
    end else begin
      rd_v1 <= is_rd;
      out_v <= rd_v1;
      if (rd_v1) out_q <= rd_word;
    end
  end

  assign dq_o = (oe_i && out_v) ? out_q : {DW{1'bz}};

  // R1: a read access reaches the output register two edges later
  a_r1_read_latency: assert property (@(posedge clk) disable iff (rst)
    is_rd |-> ##2 out_v);

  // R5: the CPU-side strobe never writes
  a_r5_cpu_strobe_reads: assert property (@(posedge clk) disable iff (rst)
    cpu_q |-> (lane_we == '0));

  // R8: an all-lane write touches every lane
  a_r8_all_lanes: assert property (@(posedge clk) disable iff (rst)
    (all_q && acc_valid && !cpu_q) |-> (&lane_we));

  // R9: a deselecting load produces no output word
  a_r9_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
    (load && !ce_q) |-> ##2 !out_v);
endmodule

// File: tb/test_burst_sram.sv
module test_burst_sram;
  localparam int L  = 4;
  localparam int AW = 8;
  localparam int DW = L * 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          ce_i = 1'b0, strb_cpu_i = 1'b0, strb_ctl_i = 1'b0, adv_i = 1'b0;
  logic [L-1:0]  lane_we_i = '0;
  logic          lane_we_en_i = 1'b0, all_we_i = 1'b0, ilv_i = 1'b0, oe_i = 1'b1;
  wire  [DW-1:0] dq_o;

  burst_sram #(.LANES(L), .ADDR_W(AW)) i_burst_sram (
    .clk(clk), .rst(rst), .addr_i(addr_i), .wdata_i(wdata_i), .ce_i(ce_i),
    .strb_cpu_i(strb_cpu_i), .strb_ctl_i(strb_ctl_i), .adv_i(adv_i),
    .lane_we_i(lane_we_i), .lane_we_en_i(lane_we_en_i), .all_we_i(all_we_i),
    .ilv_i(ilv_i), .oe_i(oe_i), .dq_o(dq_o)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference model
  logic [DW-1:0] mdl_mem [1<<AW];
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  logic          m_sel  = 1'b0;

  // scoreboard queues
  bit            q_data [$];
  logic [DW-1:0] q_val  [$];
  string         q_tag  [$];

  function automatic logic [DW-1:0] pat(input int a, input int s);
    logic [DW-1:0] r;
    for (int i = 0; i < L; i++) r[i*9 +: 9] = 9'(a * 7 + i * 53 + s * 101 + 1);
    return r;
  endfunction

  task automatic step(input logic p, input logic c, input logic a, input logic e,
                      input int ad, input logic m, input logic [L-1:0] lw,
                      input logic g, input logic [DW-1:0] wd, input string tag);
    logic          acc;
    logic [L-1:0]  mask;
    logic [1:0]    lo;
    logic [AW-1:0] ea;
    @(negedge clk);
    strb_cpu_i = p; strb_ctl_i = c; adv_i = a; ce_i = e;
    addr_i = AW'(ad); lane_we_en_i = m; lane_we_i = lw; all_we_i = g; wdata_i = wd;
    if (rst) begin
      m_sel = 1'b0; m_beat = '0; m_base = '0; acc = 1'b0;
    end else if (p || c) begin
      m_base = AW'(ad); m_beat = '0; m_sel = e; acc = e;
    end else if (a && m_sel) begin
      m_beat = m_beat + 2'd1; acc = 1'b1;
    end else acc = 1'b0;
    lo = ilv_i ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
    ea = {m_base[AW-1:2], lo};
    mask = g ? '1 : (m ? lw : '0);
    if (acc && !p && mask != '0) begin
      for (int i = 0; i < L; i++)
        if (mask[i]) mdl_mem[ea][i*9 +: 9] = wd[i*9 +: 9];
      q_data.push_back(1'b0); q_val.push_back('0);
    end else if (acc) begin
      q_data.push_back(1'b1); q_val.push_back(mdl_mem[ea]);
    end else begin
      q_data.push_back(1'b0); q_val.push_back('0);
    end
    q_tag.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 1, 0, 0, '0, 0, '0, tag);
  endtask

  task automatic rd_burst(input int ad, input string tag);
    step(1, 0, 0, 1, ad, 0, '0, 0, '0, tag);
    for (int b = 0; b < 3; b++) step(0, 0, 1, 1, 0, 0, '0, 0, '0, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q_data.size() >= 3) begin
        bit            d;
        logic [DW-1:0] v;
        string         t;
        d = q_data.pop_front(); v = q_val.pop_front(); t = q_tag.pop_front();
        checks++;
        if (!oe_i || !d) begin
          if (dq_o !== {DW{1'bz}}) begin
            failures++;
            $display("FAIL %s: dq=%h expected all Z", (!oe_i) ? "R10" : t, dq_o);
          end
        end else if (dq_o !== v) begin
          failures++;
          $display("FAIL %s: dq=%h expected %h", t, dq_o, v);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mdl_mem[i] = 'x;
    // R12: reset state
    for (int i = 0; i < 4; i++) idle("R12");
    rst = 1'b0;
    for (int i = 0; i < 2; i++) idle("R12");
    step(0, 0, 1, 1, 0, 0, '0, 0, '0, "R12");

    // R6 R8 R2: fill 0..47 with controller-strobe bursts of all-lane writes
    for (int blk = 0; blk < 12; blk++) begin
      step(0, 1, 0, 1, blk * 4, 0, '0, 1, pat(blk * 4, 0), "R6");
      for (int b = 1; b < 4; b++)
        step(0, 0, 1, 1, 0, 0, '0, 1, pat(blk * 4 + b, 0), "R2");
    end

    // R1 R3: linear read bursts
    rd_burst(5, "R3");
    rd_burst(14, "R3");
    idle("R1");
    step(1, 0, 0, 1, 9, 0, '0, 0, '0, "R1");
    idle("R1");

    // R4: interleaved order
    idle("R4"); idle("R4");
    ilv_i = 1'b1;
    idle("R4"); idle("R4");
    rd_burst(5, "R4");
    rd_burst(14, "R4");
    rd_burst(3, "R4");
    idle("R4"); idle("R4");
    ilv_i = 1'b0;
    idle("R4"); idle("R4");

    // R7: every lane-mask combination
    for (int mk = 0; mk < (1 << L); mk++) begin
      step(0, 1, 0, 1, 16 + mk, 1, L'(mk), 0, pat(16 + mk, 3), "R7");
      step(1, 0, 0, 1, 16 + mk, 0, '0, 0, '0, "R7");
    end
    // R7: master enable low blocks lane enables, access becomes a read
    step(0, 1, 0, 1, 40, 0, '1, 0, pat(40, 5), "R7");
    step(1, 0, 0, 1, 40, 0, '0, 0, '0, "R7");
    // R6: burst write with partial lanes
    step(0, 1, 0, 1, 44, 1, 4'b0101, 0, pat(44, 6), "R6");
    step(0, 0, 1, 1, 0, 1, 4'b1010, 0, pat(45, 6), "R6");
    step(0, 0, 1, 1, 0, 0, '0, 0, '0, "R6");
    step(0, 0, 1, 1, 0, 1, 4'b0001, 0, pat(47, 6), "R6");
    rd_burst(44, "R6");

    // R8: override with master and lanes low
    step(0, 1, 0, 1, 41, 0, '0, 1, pat(41, 7), "R8");
    step(1, 0, 0, 1, 41, 0, '0, 0, '0, "R8");

    // R5: CPU strobe ignores writes, and wins over controller strobe
    step(1, 0, 0, 1, 42, 1, '1, 1, pat(42, 8), "R5");
    step(1, 1, 0, 1, 43, 1, '1, 1, pat(43, 8), "R5");
    step(1, 0, 0, 1, 42, 0, '0, 0, '0, "R5");
    step(1, 0, 0, 1, 43, 0, '0, 0, '0, "R5");

    // R9: deselected load, then advances
    step(0, 1, 0, 0, 36, 0, '0, 1, pat(36, 9), "R9");
    step(0, 0, 1, 1, 0, 0, '0, 1, pat(37, 9), "R9");
    step(0, 0, 1, 1, 0, 0, '0, 0, '0, "R9");
    rd_burst(36, "R9");

    // R11: suspend in mid burst
    step(1, 0, 0, 1, 9, 0, '0, 0, '0, "R11");
    step(0, 0, 1, 1, 0, 0, '0, 0, '0, "R11");
    idle("R11"); idle("R11");
    step(0, 0, 1, 1, 0, 0, '0, 0, '0, "R11");
    step(0, 0, 1, 1, 0, 0, '0, 0, '0, "R11");

    // R10: output enable low during read beats
    rd_burst(20, "R10");
    oe_i = 1'b0;
    idle("R10"); idle("R10");
    oe_i = 1'b1;
    rd_burst(24, "R10");

    for (int i = 0; i < 4; i++) idle("R10");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule